// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block steps the downstream end of a serial link through the four equalization phases that follow a rate change to 8 GT/s. Decoded training-set fields for the lane group arrive one set per `ts_valid` strobe. The equalization-control (EC) code in those sets decides when the controller moves from one phase to the next. The block drives the transmitter setting in use, which is either a 4-bit preset or a pre/main/post cursor triple. During phase 1 it also drives the full-swing and low-frequency bounds that are advertised to the link partner.

The block has no receiver quality metric, so it never computes new settings. In phases 1 to 3 it takes the settings carried by the partner's sets and applies them back unchanged. Phases 2 and 3 are still mandatory stops. A cursor triple that lies outside the advertised bounds is refused and the previous setting is kept. A stalled phase ends in a timeout that raises an error and returns the block to idle.

Top module: `eq_phase_ctrl`

## Requirements
- R1: The phase output uses the encoding 0 = idle, 1 = EQ0, 2 = EQ1, 3 = EQ2, 4 = EQ3. It only ever holds its value, moves to the next code, or returns to 0. A set whose EC code belongs to a later phase never skips a phase.
- R2: A `speed_done` pulse in idle enters EQ0 on the next edge. On that edge it loads `start_preset` into `tx_preset` and sets `tx_use_preset` to 1. A `speed_done` pulse in any other phase has no effect.
- R3: EQ0 advances to EQ1 on an accepted set with EC = 2'b01, but only if that set completes a run of at least RUN_LEN (default 8) consecutive cleanly decoded sets received in EQ0. A valid set with `ts_decode_ok` = 0 resets the run to zero.
- R4: `adv_fs` and `adv_lf` carry FS (default 40) and LF (default 13) while the phase is EQ1, and carry 0 in every other phase.
- R5: EQ1 advances to EQ2 on an accepted set with EC = 2'b10, and the setting carried by that set is applied on the same edge.
- R6: When an applied set has `ts_use_preset` = 1, `tx_use_preset` becomes 1 and `tx_preset` takes `ts_preset`. When it has `ts_use_preset` = 0, the cursor triple is applied and `tx_use_preset` becomes 0.
- R7: In EQ2 and EQ3, every accepted set with EC = 2'b10 or 2'b11 applies its setting unchanged (echo). No other source changes the setting.
- R8: EQ2 advances to EQ3 on an accepted set with EC = 2'b11. EQ3 completes on an accepted set with EC = 2'b00. Completion returns the phase to 0 and raises `eq_done` for exactly one cycle.
- R9: A cursor triple is applied only if main <= FS and main - pre - post >= LF. Otherwise the previous setting is kept and `coef_reject` is high for one cycle, on the edge after the set.
- R10: If a non-idle phase makes no advance within TIMEOUT cycles (default 200), the phase returns to 0 and `eq_error` is set. `eq_error` stays set until the next entry into EQ0.
- R11: A set is accepted only when `ts_valid`, `ts_decode_ok` and `all_lanes` are all 1. A set that lacks any of these neither advances the phase nor applies a setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_done | input | 1 | Rate change to 8 GT/s finished |
| start_preset | input | 4 | Starting preset carried by the earlier sets |
| ts_valid | input | 1 | One decoded training set present |
| ts_decode_ok | input | 1 | Set decoded without error |
| all_lanes | input | 1 | Set captured on every lane |
| ts_ec | input | 2 | Equalization-control code |
| ts_use_preset | input | 1 | Set carries a preset rather than cursors |
| ts_preset | input | 4 | Preset field |
| ts_pre | input | 6 | Pre-cursor coefficient |
| ts_main | input | 6 | Main-cursor coefficient |
| ts_post | input | 6 | Post-cursor coefficient |
| phase | output | 3 | Current phase code |
| tx_use_preset | output | 1 | Transmitter runs from the preset |
| tx_preset | output | 4 | Preset in use |
| tx_pre | output | 6 | Pre-cursor in use |
| tx_main | output | 6 | Main-cursor in use |
| tx_post | output | 6 | Post-cursor in use |
| adv_fs | output | 6 | Advertised full swing |
| adv_lf | output | 6 | Advertised low frequency |
| eq_done | output | 1 | One-cycle completion pulse |
| eq_error | output | 1 | Timeout error, sticky |
| coef_reject | output | 1 | One-cycle refused-triple pulse |

## Verification
A wrong run count or phase code appears on `phase` on the edge after the EC-01 set. The block either advances one set too early or stays in EQ0 when it should move. A corrupt phase timer shows up as an `eq_error` edge at the wrong cycle: early, late, or while the block is idle. A fault in the bound check appears one edge after the offending set, as a changed cursor output or a missing `coef_reject` pulse. The bench compares every output against its model on every cycle, so each of these faults is reported within one clock.

// File: rtl/eq_phase_pkg.sv
package eq_phase_pkg;

    localparam int COEF_W   = 6;
    localparam int PRESET_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_EQ0  = 3'd1,
        PH_EQ1  = 3'd2,
        PH_EQ2  = 3'd3,
        PH_EQ3  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        EC_NONE = 2'b00,
        EC_P1   = 2'b01,
        EC_P2   = 2'b10,
        EC_P3   = 2'b11
    } ec_e;

    typedef struct packed {
        logic [COEF_W-1:0] pre;
        logic [COEF_W-1:0] main;
        logic [COEF_W-1:0] post;
    } cursor_t;

    typedef struct packed {
        logic                use_preset;
        logic [PRESET_W-1:0] preset;
        cursor_t             cur;
    } tx_set_t;

    function automatic logic cursor_in_bounds(cursor_t c, int fs, int lf);
        int m;
        int eff;
        m   = int'(c.main);
        eff = m - int'(c.pre) - int'(c.post);
        return (m <= fs) && (eff >= lf);
    endfunction

endpackage

// File: rtl/eq_run_counter.sv
module eq_run_counter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic set_seen,
    input  logic set_clean,
    output logic run_met
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (set_seen) begin
            if (!set_clean)
                cnt <= '0;
            else if (cnt != RW'(RUN_LEN))
                cnt <= cnt + RW'(1);
        end
    end

    // current set counts too, so one short of the limit is enough
    assign run_met = (cnt >= RW'(RUN_LEN - 1));
endmodule

// File: rtl/eq_phase_timer.sv
module eq_phase_timer #(
    parameter int TIMEOUT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (cnt != TW'(TIMEOUT - 1))
            cnt <= cnt + TW'(1);
    end

    assign expired = (cnt == TW'(TIMEOUT - 1));
endmodule

// File: rtl/eq_setting_select.sv
module eq_setting_select
    import eq_phase_pkg::*;
#(
    parameter int FS = 40,
    parameter int LF = 13
) (
    input  tx_set_t cur_set,
    input  tx_set_t rx_set,
    output tx_set_t next_set,
    output logic    refused
);
    logic fits;

    always_comb begin
        fits     = cursor_in_bounds(rx_set.cur, FS, LF);
        next_set = cur_set;
        refused  = 1'b0;
        if (rx_set.use_preset) begin
            next_set.use_preset = 1'b1;
            next_set.preset     = rx_set.preset;
        end else if (fits) begin
            next_set.use_preset = 1'b0;
            next_set.cur        = rx_set.cur;
        end else begin
            refused = 1'b1;
        end
    end
endmodule

// File: rtl/eq_phase_ctrl.sv
module eq_phase_ctrl
    import eq_phase_pkg::*;
#(
    parameter int RUN_LEN = 8,
    parameter int TIMEOUT = 200,
    parameter int FS      = 40,
    parameter int LF      = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                speed_done,
    input  logic [PRESET_W-1:0] start_preset,
    input  logic                ts_valid,
    input  logic                ts_decode_ok,
    input  logic                all_lanes,
    input  logic [1:0]          ts_ec,
    input  logic                ts_use_preset,
    input  logic [PRESET_W-1:0] ts_preset,
    input  logic [COEF_W-1:0]   ts_pre,
    input  logic [COEF_W-1:0]   ts_main,
    input  logic [COEF_W-1:0]   ts_post,
    output logic [2:0]          phase,
    output logic                tx_use_preset,
    output logic [PRESET_W-1:0] tx_preset,
    output logic [COEF_W-1:0]   tx_pre,
    output logic [COEF_W-1:0]   tx_main,
    output logic [COEF_W-1:0]   tx_post,
    output logic [COEF_W-1:0]   adv_fs,
    output logic [COEF_W-1:0]   adv_lf,
    output logic                eq_done,
    output logic                eq_error,
    output logic                coef_reject
);
    phase_e  ph_q;
    tx_set_t set_q;
    tx_set_t set_nxt;
    tx_set_t rx_set;
    logic    accepted;
    logic    run_met;
    logic    expired;
    logic    step;
    logic    apply;
    logic    refused;
    ec_e     ec;

    assign ec       = ec_e'(ts_ec);
    assign accepted = ts_valid && ts_decode_ok && all_lanes;

    assign rx_set.use_preset = ts_use_preset;
    assign rx_set.preset     = ts_preset;
    assign rx_set.cur.pre    = ts_pre;
    assign rx_set.cur.main   = ts_main;
    assign rx_set.cur.post   = ts_post;

    eq_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .clear     (ph_q != PH_EQ0),
        .set_seen  (ts_valid),
        .set_clean (ts_decode_ok),
        .run_met   (run_met)
    );

    eq_phase_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   ((ph_q == PH_IDLE) || step),
        .expired (expired)
    );

    eq_setting_select #(.FS(FS), .LF(LF)) u_sel (
        .cur_set  (set_q),
        .rx_set   (rx_set),
        .next_set (set_nxt),
        .refused  (refused)
    );

    always_comb begin
        step  = 1'b0;
        apply = 1'b0;
        unique case (ph_q)
            PH_EQ0: step = accepted && (ec == EC_P1) && run_met;
            PH_EQ1: begin
                step  = accepted && (ec == EC_P2);
                apply = step;
            end
            PH_EQ2: begin
                step  = accepted && (ec == EC_P3);
                apply = accepted && ts_ec[1];
            end
            PH_EQ3: begin
                step  = accepted && (ec == EC_NONE);
                apply = accepted && ts_ec[1];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q        <= PH_IDLE;
            set_q       <= '{use_preset: 1'b1, preset: '0, cur: '0};
            eq_done     <= 1'b0;
            eq_error    <= 1'b0;
            coef_reject <= 1'b0;
        end else begin
            eq_done     <= 1'b0;
            coef_reject <= apply && refused;
            if (apply)
                set_q <= set_nxt;
            if (ph_q == PH_IDLE) begin
                if (speed_done) begin
                    ph_q             <= PH_EQ0;
                    set_q.use_preset <= 1'b1;
                    set_q.preset     <= start_preset;
                    eq_error         <= 1'b0;
                end
            end else if (step) begin
                if (ph_q == PH_EQ3) begin
                    ph_q    <= PH_IDLE;
                    eq_done <= 1'b1;
                end else begin
                    ph_q <= phase_e'(ph_q + 3'd1);
                end
            end else if (expired) begin
                ph_q     <= PH_IDLE;
                eq_error <= 1'b1;
            end
        end
    end

    assign phase         = ph_q;
    assign tx_use_preset = set_q.use_preset;
    assign tx_preset     = set_q.preset;
    assign tx_pre        = set_q.cur.pre;
    assign tx_main       = set_q.cur.main;
    assign tx_post       = set_q.cur.post;
    assign adv_fs        = (ph_q == PH_EQ1) ? COEF_W'(FS) : '0;
    assign adv_lf        = (ph_q == PH_EQ1) ? COEF_W'(LF) : '0;

    a_r1_strict_order: assert property (@(posedge clk) disable iff (rst)
        (phase == $past(phase)) || (phase == 3'd0) || (phase == $past(phase) + 3'd1))
        else $error("R1 phase jumped");

    a_r2_entry_load: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && speed_done) |=> (phase == 3'd1 && tx_use_preset
                                            && tx_preset == $past(start_preset)))
        else $error("R2 entry load");

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        eq_done |-> (phase == 3'd0) ##1 !eq_done)
        else $error("R8 done pulse");

    a_r9_cursor_bounds: assert property (@(posedge clk) disable iff (rst)
        !tx_use_preset |-> (int'(tx_main) <= FS)
                           && (int'(tx_main) - int'(tx_pre) - int'(tx_post) >= LF))
        else $error("R9 cursor out of bounds");

    a_r9_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        coef_reject |-> (tx_pre == $past(tx_pre) && tx_main == $past(tx_main)
                         && tx_post == $past(tx_post)))
        else $error("R9 refused triple applied");

    a_r10_error_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(eq_error) |-> (phase == 3'd0))
        else $error("R10 error outside idle");

    a_r4_adv_bounds: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd2) |-> (adv_fs == '0 && adv_lf == '0))
        else $error("R4 advertised outside EQ1");
endmodule

// File: tb/tb_eq_phase_ctrl.sv
module tb_eq_phase_ctrl;
    localparam int RUN = 8;
    localparam int TO  = 200;
    localparam int FSV = 40;
    localparam int LFV = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       speed_done = 1'b0;
    logic [3:0] start_preset = 4'd0;
    logic       ts_valid = 1'b0, ts_decode_ok = 1'b0, all_lanes = 1'b0;
    logic [1:0] ts_ec = 2'b00;
    logic       ts_use_preset = 1'b0;
    logic [3:0] ts_preset = 4'd0;
    logic [5:0] ts_pre = 6'd0, ts_main = 6'd0, ts_post = 6'd0;

    logic [2:0] phase;
    logic       tx_use_preset;
    logic [3:0] tx_preset;
    logic [5:0] tx_pre, tx_main, tx_post, adv_fs, adv_lf;
    logic       eq_done, eq_error, coef_reject;

    int checks = 0;
    int bad    = 0;

    always #10 clk = ~clk;

    eq_phase_ctrl dut (
        .clk(clk), .rst(rst), .speed_done(speed_done), .start_preset(start_preset),
        .ts_valid(ts_valid), .ts_decode_ok(ts_decode_ok), .all_lanes(all_lanes),
        .ts_ec(ts_ec), .ts_use_preset(ts_use_preset), .ts_preset(ts_preset),
        .ts_pre(ts_pre), .ts_main(ts_main), .ts_post(ts_post),
        .phase(phase), .tx_use_preset(tx_use_preset), .tx_preset(tx_preset),
        .tx_pre(tx_pre), .tx_main(tx_main), .tx_post(tx_post),
        .adv_fs(adv_fs), .adv_lf(adv_lf), .eq_done(eq_done),
        .eq_error(eq_error), .coef_reject(coef_reject)
    );

    // behavioural reference model
    int m_phase, m_run, m_timer, m_preset, m_usep, m_pre, m_main, m_post;
    int m_done, m_err, m_rej;

    always @(posedge clk) begin
        bit acc, adv, app;
        int ec;
        ec  = int'(ts_ec);
        acc = ts_valid && ts_decode_ok && all_lanes;
        adv = 0;
        app = 0;
        if (rst) begin
            m_phase = 0; m_run = 0; m_timer = 0; m_preset = 0; m_usep = 1;
            m_pre = 0; m_main = 0; m_post = 0; m_done = 0; m_err = 0; m_rej = 0;
        end else begin
            m_done = 0;
            m_rej  = 0;
            if (m_phase == 1) adv = acc && ec == 1 && (m_run + 1 >= RUN);
            if (m_phase == 2) begin adv = acc && ec == 2; app = adv; end
            if (m_phase == 3) begin adv = acc && ec == 3; app = acc && ec >= 2; end
            if (m_phase == 4) begin adv = acc && ec == 0; app = acc && ec >= 2; end
            if (app) begin
                if (ts_use_preset) begin
                    m_usep = 1; m_preset = int'(ts_preset);
                end else if (int'(ts_main) <= FSV &&
                             int'(ts_main) - int'(ts_pre) - int'(ts_post) >= LFV) begin
                    m_usep = 0; m_pre = int'(ts_pre); m_main = int'(ts_main);
                    m_post = int'(ts_post);
                end else begin
                    m_rej = 1;
                end
            end
            if (m_phase == 1 && ts_valid)
                m_run = ts_decode_ok ? ((m_run + 1 > RUN) ? RUN : m_run + 1) : 0;
            else if (m_phase != 1)
                m_run = 0;
            if (m_phase == 0) begin
                m_timer = 0;
                if (speed_done) begin
                    m_phase = 1; m_usep = 1; m_preset = int'(start_preset); m_err = 0;
                    m_run = 0;
                end
            end else if (adv) begin
                m_timer = 0;
                if (m_phase == 4) begin m_phase = 0; m_done = 1; end
                else m_phase = m_phase + 1;
                m_run = 0;
            end else if (m_timer == TO - 1) begin
                m_timer = 0; m_phase = 0; m_err = 1;
            end else begin
                m_timer = m_timer + 1;
            end
        end
    end

    task automatic fail_line(string req, string what, int act, int exp);
        bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (int'(phase) != m_phase) fail_line("R1", "phase", int'(phase), m_phase);
            else if (int'(tx_use_preset) != m_usep) fail_line("R6", "use_preset", int'(tx_use_preset), m_usep);
            else if (m_usep == 1 && int'(tx_preset) != m_preset) fail_line("R6", "preset", int'(tx_preset), m_preset);
            else if (int'(tx_main) != m_main || int'(tx_pre) != m_pre || int'(tx_post) != m_post)
                fail_line("R7", "main cursor", int'(tx_main), m_main);
            else if (int'(adv_fs) != (m_phase == 2 ? FSV : 0)) fail_line("R4", "adv_fs", int'(adv_fs), m_phase == 2 ? FSV : 0);
            else if (int'(adv_lf) != (m_phase == 2 ? LFV : 0)) fail_line("R4", "adv_lf", int'(adv_lf), m_phase == 2 ? LFV : 0);
            else if (int'(eq_done) != m_done) fail_line("R8", "done", int'(eq_done), m_done);
            else if (int'(eq_error) != m_err) fail_line("R10", "error", int'(eq_error), m_err);
            else if (int'(coef_reject) != m_rej) fail_line("R9", "reject", int'(coef_reject), m_rej);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    task automatic send(int ec, bit ok, bit all, bit usep, int pst, int pr, int mn, int po);
        ts_valid = 1; ts_decode_ok = ok; all_lanes = all; ts_ec = 2'(ec);
        ts_use_preset = usep; ts_preset = 4'(pst);
        ts_pre = 6'(pr); ts_main = 6'(mn); ts_post = 6'(po);
        @(negedge clk);
        ts_valid = 0; ts_decode_ok = 0; all_lanes = 0;
    endtask

    task automatic start_eq(int pst);
        start_preset = 4'(pst); speed_done = 1;
        @(negedge clk);
        speed_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail_line("R1", "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "reset phase", int'(phase), 0);
        chk("R8", "reset done", int'(eq_done), 0);

        // R2: entry into EQ0 loads the starting preset
        start_eq(5);
        chk("R2", "enter EQ0", int'(phase), 1);
        chk("R2", "start preset", int'(tx_preset), 5);

        // R3: run broken by a failed decode
        for (int i = 0; i < 7; i++) send(0, 1, 1, 0, 0, 0, 0, 0);
        send(1, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) send(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R3", "seven after reset run stays", int'(phase), 1);
        // R1: later EC codes cannot skip ahead
        send(2, 1, 1, 0, 0, 3, 30, 3);
        chk("R1", "EC10 in EQ0", int'(phase), 1);
        send(3, 1, 1, 0, 0, 3, 30, 3);
        chk("R1", "EC11 in EQ0", int'(phase), 1);
        // R11: missing all-lanes blocks the move
        send(1, 1, 0, 0, 0, 0, 0, 0);
        chk("R11", "no all_lanes", int'(phase), 1);
        send(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R3", "leave EQ0", int'(phase), 2);
        chk("R4", "FS advertised", int'(adv_fs), FSV);

        // R2: speed_done outside idle is ignored
        start_eq(9);
        chk("R2", "speed_done ignored", int'(tx_preset), 5);
        send(3, 1, 1, 0, 0, 1, 20, 1);
        chk("R1", "EC11 in EQ1", int'(phase), 2);
        send(2, 1, 1, 0, 0, 5, 30, 8);
        chk("R5", "enter EQ2", int'(phase), 3);
        chk("R5", "captured main", int'(tx_main), 30);

        // R6, R7: echo in EQ2
        send(2, 1, 1, 1, 7, 0, 0, 0);
        chk("R6", "preset mode", int'(tx_preset), 7);
        send(2, 1, 1, 0, 0, 1, 45, 1);
        chk("R9", "main above FS kept", int'(tx_main), 30);
        send(2, 1, 1, 0, 0, 10, 30, 10);
        chk("R9", "eff below LF kept", int'(tx_pre), 5);
        send(2, 0, 1, 0, 0, 2, 33, 2);
        chk("R11", "undecoded not applied", int'(tx_main), 30);
        send(2, 1, 1, 0, 0, 0, 40, 27);
        chk("R9", "boundary accepted", int'(tx_post), 27);
        send(3, 1, 1, 0, 0, 2, 35, 4);
        chk("R8", "enter EQ3", int'(phase), 4);
        chk("R7", "echo main", int'(tx_main), 35);
        send(3, 1, 1, 1, 2, 0, 0, 0);
        chk("R7", "echo preset EQ3", int'(tx_preset), 2);
        send(0, 1, 1, 0, 0, 0, 0, 0);
        chk("R8", "done pulse", int'(eq_done), 1);
        chk("R8", "back idle", int'(phase), 0);
        @(negedge clk);
        chk("R8", "done one cycle", int'(eq_done), 0);

        // R10: timeout in EQ0
        start_eq(3);
        repeat (TO + 5) @(negedge clk);
        chk("R10", "timeout error", int'(eq_error), 1);
        chk("R10", "timeout idle", int'(phase), 0);
        start_eq(4);
        chk("R10", "error cleared", int'(eq_error), 0);
        repeat (10) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule